// File: doc/BRIEF.md
# Image Transfer Sequencing Controller

This controller sits between a byte-wide host link and an on-board pixel RAM of 8192 bytes. It runs a job in three phases: image in, processing, image out. In the first phase it takes a 64x64 image of 8-bit pixels one byte per host write strobe. Each byte goes to the next address in the lower half of the RAM, starting at address 0. Once the last pixel is stored, it waits for a processing request with a mask-size code. It then pulses a start line to the processing engine and stays idle until the engine reports completion. After that it accepts a readback command that selects one half of the RAM. It returns that half to the host one byte per read strobe and then goes back to loading.

Host strobes are synchronous and active high, and a strobe may stay high for several clock cycles. Every strobe input passes through a rising-edge detector. One strobe therefore causes at most one action, however long it lasts. A strobe that is already high when a phase begins does nothing until it falls and rises again.

The machine has five states:
- `ST_LOAD`: the idle and loading state. Writes are accepted here.
- `ST_WAIT_REQ`: waiting for a processing request.
- `ST_BUSY`: the engine is running.
- `ST_WAIT_RB`: waiting for a readback command.
- `ST_READ`: streaming one RAM half back to the host.

Its transitions are:
- LOAD to WAIT_REQ when the last pixel write is issued.
- WAIT_REQ to BUSY when a request with a valid code arrives.
- BUSY to WAIT_RB when `eng_done` is high.
- WAIT_RB to READ when a readback command arrives.
- READ to LOAD when the last read is issued.

Top module: `img_xfer_seq`

## Requirements
- R1: While reset is held and just after it, `ram_we`, `ram_re`, `eng_start` and `host_dout_valid` are 0 and `ram_addr` is 0.
- R2: In the load phase, each rising edge of `host_wr` produces exactly one cycle of `ram_we`, in the cycle after the edge is sampled. The write address is the pixel index with address bit 12 at 0 (lower half). The write data is the `host_din` byte sampled with the edge. If the strobe stays high, no further write follows.
- R3: After the 4096th pixel write, the load phase ends and further `host_wr` edges produce no RAM write.
- R4: Only in the request phase does a rising edge of `host_cmd` with `host_din[2:0]` equal to 0 (pixel-wise), 2 (2x2 mask) or 4 (4x4 mask) produce a one-cycle `eng_start` in the next cycle, with `eng_mask` equal to that code. Any other code is ignored, and so is a command given during loading.
- R5: While the engine is busy, edges on `host_wr`, `host_rd` and `host_cmd` cause no RAM access, no start and no output data.
- R6: An `eng_done` pulse ends the busy phase. A readback starts only on a later `host_cmd` edge, which latches `host_din[0]` as the half to read (0 = source/lower, 1 = result/upper). Read strobes given before that command are ignored.
- R7: In the readback phase, each rising edge of `host_rd` produces exactly one cycle of `ram_re`, in the next cycle, at address {half, pixel index}. The RAM returns the byte one cycle after `ram_re`. That byte appears on `host_dout`, with a one-cycle `host_dout_valid`, two cycles after `ram_re`.
- R8: After the 4096th read is issued, the controller returns to loading, and the next pixel write goes to address 0.
- R9: A strobe that is already high when its phase begins causes no action until it has been low for at least one sampled cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host pixel write strobe, active high, any length |
| host_rd | input | 1 | Host pixel read strobe, active high, any length |
| host_cmd | input | 1 | Host command strobe (processing request or readback order) |
| host_din | input | 8 | Pixel byte for writes; code for commands |
| host_dout | output | 8 | Byte returned to the host |
| host_dout_valid | output | 1 | One-cycle qualifier for `host_dout` |
| ram_addr | output | 13 | RAM byte address |
| ram_we | output | 1 | RAM write enable, one cycle per write |
| ram_re | output | 1 | RAM read enable, one cycle per read |
| ram_wdata | output | 8 | RAM write data |
| ram_rdata | input | 8 | RAM read data, valid one cycle after `ram_re` |
| eng_start | output | 1 | One-cycle start pulse to the processing engine |
| eng_mask | output | 3 | Mask-size code given to the engine |
| eng_done | input | 1 | Engine completion pulse |

## Verification
The inputs are driven at falling edges. A strobe first seen at rising edge E0 has its `ram_we`, `ram_re` or `eng_start` checked at the next falling edge. At the falling edge after that, the same signal is checked to have dropped while the strobe is still high. Returned data passes through the RAM register and the capture register, so `host_dout` and `host_dout_valid` are sampled at the third falling edge after the read strobe is raised. For the ignored-input cases, every RAM control and result output is checked to stay at 0 over the whole strobe and the cycle after it.

// File: rtl/imgseq_pkg.sv
package imgseq_pkg;

    // Phase machine states
    typedef enum logic [2:0] {
        ST_LOAD     = 3'd0,
        ST_WAIT_REQ = 3'd1,
        ST_BUSY     = 3'd2,
        ST_WAIT_RB  = 3'd3,
        ST_READ     = 3'd4
    } seq_state_t;

    // Mask-size request codes
    localparam logic [2:0] MASK_PIXEL = 3'd0;
    localparam logic [2:0] MASK_2X2   = 3'd2;
    localparam logic [2:0] MASK_4X4   = 3'd4;

    // Strobe lane positions inside the edge detector vector
    localparam int LANE_WR  = 0;
    localparam int LANE_RD  = 1;
    localparam int LANE_CMD = 2;
    localparam int N_LANES  = 3;

    function automatic logic mask_code_ok(input logic [2:0] code);
        return (code == MASK_PIXEL) || (code == MASK_2X2) || (code == MASK_4X4);
    endfunction

endpackage

// File: rtl/strobe_edge.sv
module strobe_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] strobe,
    output logic [N-1:0] rise
);

    // One history flop per lane; a lane fires only on a low-to-high change
    for (genvar g = 0; g < N; g++) begin : g_lane
        logic seen_q;

        always_ff @(posedge clk) begin
            if (!rst_n) seen_q <= 1'b0;
            else        seen_q <= strobe[g];
        end

        assign rise[g] = strobe[g] & ~seen_q;
    end

endmodule

// File: rtl/pixel_counter.sv
module pixel_counter #(
    parameter int CNT_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt,
    output logic             last
);

    localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

    always_ff @(posedge clk) begin
        if (!rst_n)   cnt <= '0;
        else if (clr) cnt <= '0;
        else if (inc) cnt <= cnt + 1'b1;   // wraps to zero after TOP
    end

    assign last = (cnt == TOP);

endmodule

// File: rtl/readback_pipe.sv
module readback_pipe #(
    parameter int PIX_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ram_re,
    input  logic [PIX_W-1:0] ram_rdata,
    output logic [PIX_W-1:0] dout,
    output logic             dout_valid
);

    // RAM presents data one cycle after ram_re; capture it the cycle after
    logic re_d;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            re_d       <= 1'b0;
            dout       <= '0;
            dout_valid <= 1'b0;
        end else begin
            re_d       <= ram_re;
            dout_valid <= re_d;
            if (re_d) dout <= ram_rdata;
        end
    end

endmodule

// File: rtl/img_xfer_seq.sv
module img_xfer_seq
    import imgseq_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 64,
    parameter int PIX_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 host_wr,
    input  logic                 host_rd,
    input  logic                 host_cmd,
    input  logic [PIX_W-1:0]     host_din,
    output logic [PIX_W-1:0]     host_dout,
    output logic                 host_dout_valid,
    output logic [$clog2(IMG_W*IMG_H):0] ram_addr,
    output logic                 ram_we,
    output logic                 ram_re,
    output logic [PIX_W-1:0]     ram_wdata,
    input  logic [PIX_W-1:0]     ram_rdata,
    output logic                 eng_start,
    output logic [2:0]           eng_mask,
    input  logic                 eng_done
);

    localparam int NPIX   = IMG_W * IMG_H;
    localparam int CNT_W  = $clog2(NPIX);
    localparam int ADDR_W = CNT_W + 1;

    seq_state_t state, state_nx;

    logic [N_LANES-1:0] rise;
    logic [CNT_W-1:0]   pix_idx;
    logic               pix_last;
    logic               rd_half;

    logic wr_go, rd_go, req_go, rb_go;

    // Edge detection of all host strobes
    strobe_edge #(.N(N_LANES)) u_edge (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe ({host_cmd, host_rd, host_wr}),
        .rise   (rise)
    );

    // Qualified events, one per phase
    assign wr_go  = rise[LANE_WR]  && (state == ST_LOAD);
    assign rd_go  = rise[LANE_RD]  && (state == ST_READ);
    assign req_go = rise[LANE_CMD] && (state == ST_WAIT_REQ) && mask_code_ok(host_din[2:0]);
    assign rb_go  = rise[LANE_CMD] && (state == ST_WAIT_RB);

    // Shared pixel index for loading and readback
    pixel_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (rb_go),
        .inc   (wr_go | rd_go),
        .cnt   (pix_idx),
        .last  (pix_last)
    );

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_LOAD:     if (wr_go && pix_last) state_nx = ST_WAIT_REQ;
            ST_WAIT_REQ: if (req_go)            state_nx = ST_BUSY;
            ST_BUSY:     if (eng_done)          state_nx = ST_WAIT_RB;
            ST_WAIT_RB:  if (rb_go)             state_nx = ST_READ;
            ST_READ:     if (rd_go && pix_last) state_nx = ST_LOAD;
            default:                            state_nx = ST_LOAD;
        endcase
    end

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_LOAD;
        else        state <= state_nx;
    end

    // Registered outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ram_addr  <= '0;
            ram_we    <= 1'b0;
            ram_re    <= 1'b0;
            ram_wdata <= '0;
            eng_start <= 1'b0;
            eng_mask  <= MASK_PIXEL;
            rd_half   <= 1'b0;
        end else begin
            ram_we    <= 1'b0;
            ram_re    <= 1'b0;
            eng_start <= 1'b0;
            if (wr_go) begin
                ram_we    <= 1'b1;
                ram_addr  <= {1'b0, pix_idx};
                ram_wdata <= host_din;
            end
            if (rd_go) begin
                ram_re   <= 1'b1;
                ram_addr <= {rd_half, pix_idx};
            end
            if (req_go) begin
                eng_start <= 1'b1;
                eng_mask  <= host_din[2:0];
            end
            if (rb_go) rd_half <= host_din[0];
        end
    end

    // Return path to the host
    readback_pipe #(.PIX_W(PIX_W)) u_rb (
        .clk        (clk),
        .rst_n      (rst_n),
        .ram_re     (ram_re),
        .ram_rdata  (ram_rdata),
        .dout       (host_dout),
        .dout_valid (host_dout_valid)
    );

    // Keeps the derived address width and the port width tied together
    logic [ADDR_W-1:0] addr_w_probe;
    assign addr_w_probe = ram_addr;

endmodule

// File: rtl/img_xfer_seq_chk.sv
module img_xfer_seq_chk
    import imgseq_pkg::*;
#(
    parameter int IMG_W = 64,
    parameter int IMG_H = 64,
    parameter int PIX_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [PIX_W-1:0]     host_din,
    input logic                 ram_we,
    input logic                 ram_re,
    input logic [$clog2(IMG_W*IMG_H):0] ram_addr,
    input logic [PIX_W-1:0]     ram_wdata,
    input logic                 eng_start,
    input logic [2:0]           eng_mask,
    input logic                 host_dout_valid,
    input seq_state_t           state
);

    localparam int MSB = $clog2(IMG_W * IMG_H);

    // R1
    reset_idle_chk: assert property (@(posedge clk) !rst_n |=> !ram_we && !ram_re && !eng_start);

    // R2
    we_single_chk: assert property (@(posedge clk) disable iff (!rst_n) ram_we |=> !ram_we);

    // R2
    we_lower_half_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_addr[MSB] == 1'b0) && (ram_wdata == $past(host_din)));

    // R4
    start_single_chk: assert property (@(posedge clk) disable iff (!rst_n) eng_start |=> !eng_start);

    // R4
    start_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eng_start |-> mask_code_ok(eng_mask));

    // R5
    busy_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(state) == ST_BUSY) |-> !ram_we && !ram_re && !eng_start);

    // R7
    re_single_chk: assert property (@(posedge clk) disable iff (!rst_n) ram_re |=> !ram_re);

    // R7
    re_in_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ram_re |-> $past(state) == ST_READ);

    // R7
    dout_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        host_dout_valid |-> $past(ram_re, 2));

    // R7
    no_we_re_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n) !(ram_we && ram_re));

endmodule

bind img_xfer_seq img_xfer_seq_chk #(
    .IMG_W (IMG_W),
    .IMG_H (IMG_H),
    .PIX_W (PIX_W)
) u_chk (
    .clk             (clk),
    .rst_n           (rst_n),
    .host_din        (host_din),
    .ram_we          (ram_we),
    .ram_re          (ram_re),
    .ram_addr        (ram_addr),
    .ram_wdata       (ram_wdata),
    .eng_start       (eng_start),
    .eng_mask        (eng_mask),
    .host_dout_valid (host_dout_valid),
    .state           (state)
);

// File: tb/sim_img_xfer_seq.sv
module sim_img_xfer_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NPIX       = 4096;
    localparam int AW         = 13;
    localparam int WATCHDOG   = 200000;

    // Per-round vectors: {mask code[2:0], readback half}
    localparam logic [3:0] ROUNDS [0:2] = '{4'b010_1, 4'b000_0, 4'b100_1};
    localparam logic [2:0] BAD_CODES [0:3] = '{3'd1, 3'd3, 3'd5, 3'd7};

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          host_wr = 1'b0, host_rd = 1'b0, host_cmd = 1'b0;
    logic [7:0]    host_din = '0;
    logic [7:0]    host_dout;
    logic          host_dout_valid;
    logic [AW-1:0] ram_addr;
    logic          ram_we, ram_re;
    logic [7:0]    ram_wdata;
    logic [7:0]    ram_rdata = '0;
    logic          eng_start;
    logic [2:0]    eng_mask;
    logic          eng_done = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    img_xfer_seq u0 (
        .clk (clk), .rst_n (rst_n),
        .host_wr (host_wr), .host_rd (host_rd), .host_cmd (host_cmd),
        .host_din (host_din), .host_dout (host_dout), .host_dout_valid (host_dout_valid),
        .ram_addr (ram_addr), .ram_we (ram_we), .ram_re (ram_re),
        .ram_wdata (ram_wdata), .ram_rdata (ram_rdata),
        .eng_start (eng_start), .eng_mask (eng_mask), .eng_done (eng_done)
    );

    // Stored content seen on readback, a function of the address
    function automatic logic [7:0] ram_pat(input logic [AW-1:0] a);
        return a[7:0] ^ {a[12:8], 3'b011};
    endfunction

    always @(posedge clk) if (ram_re) ram_rdata <= ram_pat(ram_addr);

    task automatic check_eq(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic quiet(input int n, input string req);
        repeat (n) begin
            @(negedge clk);
            check_eq(req, "ram_we", ram_we, 0);
            check_eq(req, "ram_re", ram_re, 0);
            check_eq(req, "eng_start", eng_start, 0);
            check_eq(req, "dout_valid", host_dout_valid, 0);
        end
    endtask

    // which: 0 write, 1 read, 2 command; expects no action at all
    task automatic ignored_strobe(input int which, input string req);
        if (which == 0) host_wr = 1'b1; else if (which == 1) host_rd = 1'b1; else host_cmd = 1'b1;
        quiet(2, req);
        host_wr = 1'b0; host_rd = 1'b0; host_cmd = 1'b0;
        quiet(1, req);
    endtask

    task automatic write_pixel(input int idx, input logic [7:0] d, input int hold, input string req);
        host_din = d;
        host_wr  = 1'b1;
        @(negedge clk);
        check_eq(req, "ram_we", ram_we, 1);
        check_eq(req, "ram_addr", ram_addr, idx);
        check_eq(req, "ram_wdata", ram_wdata, d);
        for (int k = 1; k < hold; k++) begin
            @(negedge clk);
            check_eq("R2", "ram_we held strobe", ram_we, 0);
        end
        host_wr = 1'b0;
        @(negedge clk);
    endtask

    task automatic read_pixel(input int idx, input logic half);
        logic [AW-1:0] a;
        a = {half, idx[11:0]};
        host_rd = 1'b1;
        @(negedge clk);
        check_eq("R7", "ram_re", ram_re, 1);
        check_eq("R7", "ram_addr", ram_addr, a);
        @(negedge clk);
        check_eq("R7", "ram_re held strobe", ram_re, 0);
        host_rd = 1'b0;
        @(negedge clk);
        check_eq("R7", "dout_valid", host_dout_valid, 1);
        check_eq("R7", "host_dout", host_dout, ram_pat(a));
    endtask

    task automatic send_cmd(input logic [7:0] d, input bit exp_start, input logic [2:0] exp_mask,
                            input string req);
        host_din = d;
        host_cmd = 1'b1;
        @(negedge clk);
        check_eq(req, "eng_start", eng_start, exp_start);
        if (exp_start) check_eq(req, "eng_mask", eng_mask, exp_mask);
        @(negedge clk);
        check_eq(req, "eng_start second cycle", eng_start, 0);
        host_cmd = 1'b0;
        @(negedge clk);
    endtask

    // Watchdog
    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual expired expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // R1: reset state
        repeat (3) @(negedge clk);
        check_eq("R1", "ram_we", ram_we, 0);
        check_eq("R1", "ram_re", ram_re, 0);
        check_eq("R1", "eng_start", eng_start, 0);
        check_eq("R1", "dout_valid", host_dout_valid, 0);
        check_eq("R1", "ram_addr", ram_addr, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check_eq("R1", "ram_we after release", ram_we, 0);

        for (int r = 0; r < 3; r++) begin
            logic [2:0] code;
            logic       half;
            code = ROUNDS[r][3:1];
            half = ROUNDS[r][0];

            // R4: a request during loading is ignored
            if (r == 0) send_cmd(8'd2, 1'b0, 3'd0, "R4");

            // R2 / R8: image in
            for (int i = 0; i < NPIX; i++) begin
                logic [7:0] d;
                d = 8'((i * 5 + r * 29 + 1) & 255);
                write_pixel(i, d, (r == 0 && i == 0) ? 4 : 2,
                            (r > 0 && i == 0) ? "R8" : "R2");
            end

            // R3: load phase closed
            ignored_strobe(0, "R3");

            // R4: bad codes ignored, then the real request
            foreach (BAD_CODES[b]) send_cmd({5'd0, BAD_CODES[b]}, 1'b0, 3'd0, "R4");
            send_cmd({5'd0, code}, 1'b1, code, "R4");

            // R5: busy ignores every strobe
            ignored_strobe(0, "R5");
            ignored_strobe(1, "R5");
            ignored_strobe(2, "R5");

            // R6: completion, then read strobe before the readback order
            eng_done = 1'b1;
            @(negedge clk);
            eng_done = 1'b0;
            ignored_strobe(1, "R6");

            // R9: read strobe held high across the readback order
            host_rd = 1'b1;
            @(negedge clk);
            send_cmd({7'd0, half}, 1'b0, 3'd0, "R6");
            quiet(2, "R9");
            host_rd = 1'b0;
            @(negedge clk);

            // R7: image out
            for (int i = 0; i < NPIX; i++) read_pixel(i, half);
        end

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule